// File: doc/BRIEF.md
# Page-Secured Memory Response Gate

This block guards a single-beat slave port in front of an on-chip RAM and a boot ROM. For every request it decides whether the access may reach the memory. It then returns the response code together with the request's ID. Each mapped 4 KB page carries one security bit. A non-secure request aimed at a secure page is stopped before the memory and answered with a decode error. Addresses that fall outside both regions are answered with a slave error. When parity checking is switched on, a read that the memory flags with a parity error is also answered with a slave error.

Exclusive requests are not supported. An exclusive read is served as a normal read. An exclusive write leaves the memory untouched. Both are answered with plain OKAY, which tells the master that the exclusive attempt failed. A separate configuration port loads the page security map as a whole. The memory is expected to have one cycle of read latency: it samples the enable in the request cycle and presents read data and its parity flag in the cycle after. The response is registered one cycle after that.

Top module: `secmem_resp_gate`

## Requirements
- R1: A request with `reqProt[1]` = 1 (non-secure) to a mapped page whose security bit is 1 is answered with DECERR (2'b11). It raises neither `memEn` nor `memWe`, and it returns zero data.
- R2: A request that is neither blocked nor in error is answered with OKAY (2'b00). A read returns the word the memory holds at that address. A secure request (`reqProt[1]` = 0) is never blocked by the security map.
- R3: The security map holds one bit per page, where 1 means secure. Bits 0 to RAM_PAGES-1 cover RAM pages 0 upward, starting at address 0. The bits above them cover the ROM pages from page ROM_BASE_PAGE upward. Reset sets every bit. A `cfgWe` pulse replaces the whole map with `cfgMap`, and the new map governs requests from the following cycle on.
- R4: A request whose page lies in neither region is answered with SLVERR (2'b10), whatever its protection bits. It raises neither `memEn` nor `memWe`.
- R5: When an allowed read is answered, `parityEn` = 1 and `memParityErr` = 1 in the cycle after the request turn the response into SLVERR with zero data.
- R6: With `parityEn` = 0, a parity flag on an allowed read is ignored: the response is OKAY and carries the read data.
- R7: The parity flag has no effect on writes or on blocked requests. Their response is unchanged.
- R8: An exclusive request (`reqLock` = 1) is never answered with EXOKAY (2'b01). An exclusive write raises neither `memEn` nor `memWe` and completes with OKAY. An exclusive read reads the memory like any other read.
- R9: Every request cycle with `reqValid` = 1 yields exactly one `rspValid` pulse two cycles later, with the request's `reqId`. `rspValid` is low in all other cycles.
- R10: An allowed non-exclusive write raises `memEn` and `memWe` in the request cycle, with `memAddr` and `memWdata` equal to the request. An allowed read raises `memEn` without `memWe`. Neither strobe is raised without `reqValid`.
- R11: While `rstN` is low, `rspValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Load the security map |
| cfgMap | input | RAM_PAGES+ROM_PAGES | New security map, one bit per page (1 = secure) |
| parityEn | input | 1 | Report read parity errors |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLock | input | 1 | Exclusive request |
| reqProt | input | 3 | Protection bits; bit 1 set means non-secure |
| reqId | input | ID_W | Request ID |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Write data |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid the cycle after `memEn` |
| memParityErr | input | 1 | Parity error on the read data, same cycle as `memRdata` |
| rspValid | output | 1 | Response present |
| rspResp | output | 2 | Response code |
| rspId | output | ID_W | ID of the request being answered |
| rspData | output | DATA_W | Read data, zero for writes and errors |

## Verification
Because the design is pipelined, two of its functions meet in the same cycle. The security and address decision for a new request is made while the parity flag of the previous read is being resolved. The parity flag can also arrive for a request that was blocked or that was a write. The bench drives the parity flag and its enable independently of the access type, on back-to-back random requests mixed with map reloads. It compares every response against a code computed from the bench's own copy of the map. This exposes a parity error that leaks into a DECERR, reserved or write response, or into the neighbouring request. Directed cases add a map reload in the same cycle as a request, to show which map that request sees.

// File: rtl/secmem_pkg.sv
package secmem_pkg;

  localparam int PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } axiResp_e;

  typedef enum logic [1:0] {
    PEND_NONE     = 2'd0,
    PEND_SECURE   = 2'd1,
    PEND_RESERVED = 2'd2
  } pend_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic memEn;
    logic memWe;
    logic keepData;
  } dpStrobe_t;

endpackage

// File: rtl/secmem_ctrl.sv
module secmem_ctrl
  import secmem_pkg::*;
#(
  parameter int PAGE_W        = 4,
  parameter int RAM_PAGES     = 4,
  parameter int ROM_PAGES     = 2,
  parameter int ROM_BASE_PAGE = 8,
  localparam int MAP_W        = RAM_PAGES + ROM_PAGES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [MAP_W-1:0]  cfgMap,
  input  logic              parityEn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqLock,
  input  logic [2:0]        reqProt,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              memParityErr,
  output dpStrobe_t         strobe,
  output logic              rspValid,
  output logic [1:0]        rspResp
);

  logic [MAP_W-1:0] secMap;
  logic [MAP_W-1:0] pageHit;
  logic             mapped;
  logic             secureHit;
  logic             violation;
  logic             allowed;
  logic             exclWrite;
  logic             reqNonSecure;
  logic             protUnused;
  pend_e            pendNext;

  logic             s1Valid;
  logic             s1Read;
  pend_e            s1Pend;
  logic             parityHit;
  axiResp_e         finalResp;

  assign reqNonSecure = reqProt[1];
  assign protUnused   = reqProt[2] ^ reqProt[0];

  // Security map: resets to all pages secure
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      secMap <= '1;
    else if (cfgWe) secMap <= cfgMap;
  end

  // One comparator per mapped page
  for (genvar gi = 0; gi < MAP_W; gi++) begin : g_page
    localparam int PAGE_NO = (gi < RAM_PAGES) ? gi : ROM_BASE_PAGE + gi - RAM_PAGES;
    assign pageHit[gi] = (reqPage == PAGE_W'(PAGE_NO));
  end

  always_comb begin
    mapped    = |pageHit;
    secureHit = |(pageHit & secMap);
    violation = reqNonSecure & secureHit;
    allowed   = reqValid & mapped & ~violation;
    exclWrite = reqWrite & reqLock;
    // Security first, then reserved space
    if (violation)   pendNext = PEND_SECURE;
    else if (!mapped) pendNext = PEND_RESERVED;
    else             pendNext = PEND_NONE;
    strobe.memEn = allowed & ~exclWrite;
    strobe.memWe = allowed & reqWrite & ~reqLock;
  end

  // Stage 1: decision travels with the memory access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Read  <= 1'b0;
      s1Pend  <= PEND_NONE;
    end else begin
      s1Valid <= reqValid;
      s1Read  <= allowed & ~reqWrite;
      s1Pend  <= pendNext;
    end
  end

  // Stage 2: merge with parity from the read path
  always_comb begin
    parityHit       = s1Read & parityEn & memParityErr;
    strobe.keepData = s1Read & ~(parityEn & memParityErr);
    unique case (s1Pend)
      PEND_SECURE:   finalResp = RESP_DECERR;
      PEND_RESERVED: finalResp = RESP_SLVERR;
      default:       finalResp = parityHit ? RESP_SLVERR : RESP_OKAY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspResp  <= RESP_OKAY;
    end else begin
      rspValid <= s1Valid;
      rspResp  <= s1Valid ? finalResp : RESP_OKAY;
    end
  end

endmodule

// File: rtl/secmem_datapath.sv
module secmem_datapath
  import secmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ID_W-1:0]   rspId,
  output logic [DATA_W-1:0] rspData
);

  logic [ID_W-1:0] s1Id;

  assign memEn    = strobe.memEn;
  assign memWe    = strobe.memWe;
  assign memAddr  = strobe.memEn ? reqAddr : '0;
  assign memWdata = strobe.memWe ? reqWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Id    <= '0;
      rspId   <= '0;
      rspData <= '0;
    end else begin
      s1Id    <= reqId;
      rspId   <= s1Id;
      rspData <= strobe.keepData ? memRdata : '0;
    end
  end

endmodule

// File: rtl/secmem_resp_gate.sv
module secmem_resp_gate
  import secmem_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 32,
  parameter int ID_W          = 4,
  parameter int RAM_PAGES     = 4,
  parameter int ROM_PAGES     = 2,
  parameter int ROM_BASE_PAGE = 8,
  localparam int MAP_W        = RAM_PAGES + ROM_PAGES,
  localparam int PAGE_W       = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [MAP_W-1:0]  cfgMap,
  input  logic              parityEn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqLock,
  input  logic [2:0]        reqProt,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memParityErr,
  output logic              rspValid,
  output logic [1:0]        rspResp,
  output logic [ID_W-1:0]   rspId,
  output logic [DATA_W-1:0] rspData
);

  dpStrobe_t strobe;

  secmem_ctrl #(
    .PAGE_W(PAGE_W), .RAM_PAGES(RAM_PAGES),
    .ROM_PAGES(ROM_PAGES), .ROM_BASE_PAGE(ROM_BASE_PAGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMap(cfgMap),
    .parityEn(parityEn), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLock(reqLock), .reqProt(reqProt),
    .reqPage(reqAddr[ADDR_W-1:PAGE_SHIFT]),
    .memParityErr(memParityErr), .strobe(strobe),
    .rspValid(rspValid), .rspResp(rspResp)
  );

  secmem_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqId(reqId),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memRdata(memRdata),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .rspId(rspId), .rspData(rspData)
  );

endmodule

// File: rtl/secmem_resp_gate_checker.sv
module secmem_resp_gate_checker #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqLock,
  input logic [ID_W-1:0]   reqId,
  input logic              memEn,
  input logic              memWe,
  input logic              rspValid,
  input logic [1:0]        rspResp,
  input logic [ID_W-1:0]   rspId,
  input logic [DATA_W-1:0] rspData
);

  logic [1:0] sinceReset;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceReset <= 2'd0;
    else if (sinceReset != 2'd2) sinceReset <= sinceReset + 2'd1;
  end
  assign warm = (sinceReset == 2'd2);

  assert_decerr_no_access_R1: assert property (@(posedge clk) disable iff (!rstN)
    warm && rspValid && rspResp == 2'b11 |-> !$past(memEn, 2));

  assert_error_zero_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspResp != 2'b00 |-> rspData == '0);

  assert_never_exokay_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspResp != 2'b01);

  assert_excl_write_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && reqLock |-> !memEn && !memWe);

  assert_one_response_R9: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> rspValid == $past(reqValid, 2));

  assert_response_id_R9: assert property (@(posedge clk) disable iff (!rstN)
    warm && rspValid |-> rspId == $past(reqId, 2));

  assert_write_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);

  assert_strobe_needs_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> reqValid);

endmodule

bind secmem_resp_gate secmem_resp_gate_checker #(.ID_W(ID_W), .DATA_W(DATA_W)) u_checker (.*);

// File: tb/secmem_resp_gate_bench.sv
module secmem_resp_gate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgMap = '0;
  logic        parityEn = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqLock = 1'b0;
  logic [2:0]  reqProt = '0;
  logic [3:0]  reqId = '0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        memEn, memWe;
  logic [15:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        memParityErr = 1'b0;
  logic        rspValid;
  logic [1:0]  rspResp;
  logic [3:0]  rspId;
  logic [31:0] rspData;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  secmem_resp_gate u_secmem_resp_gate (.*);

  // Memory model, one cycle read latency
  logic [31:0] mem    [0:63];
  logic [31:0] shadow [0:63];
  function automatic int key(input logic [15:0] a);
    return int'({a[15:12], a[3:2]});
  endfunction
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[key(memAddr)] <= memWdata;
      memRdata <= mem[key(memAddr)];
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Expected pipeline and bench map
  bit          e1v, e2v;
  logic [1:0]  e1r, e2r;
  logic [31:0] e1d, e2d;
  logic [3:0]  e1i, e2i;
  string       e1t, e2t;
  bit          pendPar, pendEn;
  logic [5:0]  mapS = 6'h3F;
  logic [3:0]  idCnt = '0;

  task automatic step(input bit v, input bit w, input bit lk, input bit ns,
                      input logic [15:0] a, input logic [31:0] wd,
                      input bit cw, input logic [5:0] cm,
                      input bit pf, input bit pe, input string tagOv);
    int idx;
    bit mapped, viol, allowed, doEn, doWe, readOk;
    logic [1:0] r;
    logic [31:0] d;
    string t, ts;
    @(negedge clk);
    if (e2v) begin
      chk(e2t, "rspValid", 32'(rspValid), 32'd1);
      chk(e2t, "rspResp", 32'(rspResp), 32'(e2r));
      chk(e2t, "rspData", rspData, e2d);
      chk("R9", "rspId", 32'(rspId), 32'(e2i));
    end else begin
      chk("R9", "rspValid idle", 32'(rspValid), 32'd0);
    end
    e2v = e1v; e2r = e1r; e2d = e1d; e2i = e1i; e2t = e1t;
    memParityErr = pendPar;
    parityEn     = pendEn;
    // expected outcome for the new request
    idx = -1;
    if (a[15:12] < 4) idx = int'(a[15:12]);
    else if (a[15:12] == 4'd8 || a[15:12] == 4'd9) idx = 4 + int'(a[15:12]) - 8;
    mapped  = (idx >= 0);
    viol    = mapped && ns && mapS[idx];
    allowed = v && mapped && !viol;
    doEn    = allowed && !(w && lk);
    doWe    = allowed && w && !lk;
    readOk  = allowed && !w;
    if (viol) r = 2'b11;
    else if (!mapped) r = 2'b10;
    else if (readOk && pf && pe) r = 2'b10;
    else r = 2'b00;
    d = (readOk && r == 2'b00) ? shadow[key(a)] : 32'h0;
    if (viol) t = "R1";
    else if (!mapped) t = "R4";
    else if (readOk && pf && pe) t = "R5";
    else if (readOk && pf) t = "R6";
    else if (pf) t = "R7";
    else if (lk) t = "R8";
    else t = "R2";
    if (tagOv != "") t = tagOv;
    ts = !v ? "R10" : viol ? "R1" : !mapped ? "R4" : (w && lk) ? "R8" : "R10";
    e1v = v; e1r = r; e1d = d; e1i = idCnt; e1t = t;
    pendPar = pf; pendEn = pe;
    reqValid = v; reqWrite = w; reqLock = lk; reqProt = {1'b0, ns, 1'b0};
    reqAddr = a; reqWdata = wd; reqId = idCnt; cfgWe = cw; cfgMap = cm;
    if (v) idCnt = idCnt + 4'd1;
    #1;
    chk(ts, "memEn", 32'(memEn), 32'(doEn));
    chk(ts, "memWe", 32'(memWe), 32'(doWe));
    if (doWe) begin
      chk("R10", "memAddr", 32'(memAddr), 32'(a));
      chk("R10", "memWdata", memWdata, wd);
      shadow[key(a)] = wd;
    end
    if (cw) mapS = cm;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 6'h0, 1'b0, 1'b0, "");
  endtask

  function automatic logic [15:0] randAddr();
    int reg3, p;
    logic [3:0] page;
    reg3 = int'($urandom % 3);
    if (reg3 == 0) page = 4'($urandom % 4);
    else if (reg3 == 1) page = 4'(8 + $urandom % 2);
    else begin
      p = int'($urandom % 10);
      page = (p < 4) ? 4'(4 + p) : 4'(6 + p);
    end
    return {page, 10'($urandom % 1024), 2'b00};
  endfunction

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC0_0A11));
    for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R11", "rspValid in reset", 32'(rspValid), 32'd0);
    chk("R11", "rspResp in reset", 32'(rspResp), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    // R3: reset map makes every page secure
    step(1, 0, 0, 1, 16'h0010, 0, 0, 0, 0, 0, "R3");
    // R10/R2: secure write then read back
    step(1, 1, 0, 0, 16'h1020, 32'hCAFE_0001, 0, 0, 0, 0, "");
    step(1, 0, 0, 0, 16'h1020, 0, 0, 0, 0, 0, "R2");
    // R3: map reload in same cycle uses old map; next cycle the new one
    step(1, 0, 0, 1, 16'h1020, 0, 1, 6'b011101, 0, 0, "R3");
    step(1, 0, 0, 1, 16'h1020, 0, 0, 0, 0, 0, "R3");
    // ROM pages: page 8 secure, page 9 opened
    step(1, 0, 0, 1, 16'h8004, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 1, 16'h9004, 0, 0, 0, 0, 0, "R3");
    // R4: reserved space, both security levels
    step(1, 0, 0, 0, 16'h4000, 0, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 1, 16'hA008, 32'h1, 0, 0, 0, 0, "R4");
    // parity cases
    step(1, 0, 0, 0, 16'h1020, 0, 0, 0, 1, 1, "R5");
    step(1, 0, 0, 0, 16'h1020, 0, 0, 0, 1, 0, "R6");
    step(1, 1, 0, 0, 16'h2040, 32'h55AA_33CC, 0, 0, 1, 1, "R7");
    step(1, 0, 0, 1, 16'h0040, 0, 0, 0, 1, 1, "R7");
    // exclusive write leaves memory alone; exclusive read served
    step(1, 1, 1, 0, 16'h2040, 32'hDEAD_BEEF, 0, 0, 0, 0, "R8");
    step(1, 0, 1, 0, 16'h2040, 0, 0, 0, 0, 0, "R8");
    idle();
    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      bit v, w, lk, ns, cw, pf, pe;
      v  = ($urandom % 10) < 8;
      w  = $urandom % 2;
      lk = ($urandom % 100) < 15;
      ns = $urandom % 2;
      cw = ($urandom % 100) < 5;
      pf = ($urandom % 10) < 2;
      pe = ($urandom % 10) < 7;
      step(v, w, lk, ns, randAddr(), $urandom, cw, 6'($urandom), pf, pe, "");
    end
    idle();
    idle();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule